// File: doc/BRIEF.md
# Exception Vector and Escalation Controller

This block sits beside an instruction execution unit and turns exception requests into a delivery decision. Each request names one or more causes on a cause bus. The block picks a single winner, gives it a vector number and a class (fault, trap or abort), and tells the front end whether the saved return point is the faulting instruction or the one after it. Software interrupts take their vector from an immediate operand. The overflow-check interrupt only fires when the overflow flag is set. Some causes cannot occur in real mode and are dropped there.

The block also tracks nested handler invocation. After it delivers an exception, it waits in an "invoking" level until the execution unit strobes invocation-done. A fault that arrives during that window is turned into a double fault (vector 8, abort). Any further exception that arrives while the double-fault handler is being invoked sends the block into shutdown. On entry it raises a one-cycle broadcast request and then holds a shutdown level until reset.

All outputs are registered and appear in the cycle after the clock edge that samples the request.

Top module: `exc_escalator`

## Requirements
- R1: While reset is active and directly after it, exc_valid_o, shutdown_o and shutdown_req_o are 0.
- R2: A software interrupt (cause bit 10) delivers the swint_imm_i value as the vector with class trap (exc_class_o = 1) and ret_next_o = 1, one cycle after the sampling edge.
- R3: The overflow-check interrupt (cause bit 2) delivers vector 4 as a trap only when ovf_i is 1. With ovf_i = 0 nothing is delivered and the escalation level is unchanged.
- R4: The breakpoint interrupt (cause bit 1) delivers vector 3 as a trap with ret_next_o = 1.
- R5: Divide by zero (bit 0) gives vector 0, array bounds (bit 3) gives 5, invalid opcode (bit 4) gives 6 and general protection (bit 8) gives 13. All are class fault (exc_class_o = 0) with ret_next_o = 0.
- R6: A not-present segment gives vector 12 for the stack segment (bit 7) and vector 11 for any other segment (bit 6).
- R7: With real_mode_i = 1, the invalid-task-state (bit 5, vector 10), segment-not-present (bit 6) and page-fault (bit 9, vector 14) causes are dropped. The stack cause (bit 7) is not dropped.
- R8: When several live causes are present, the lowest vector wins. If a software-interrupt immediate ties with a fixed cause, the fixed cause wins.
- R9: A fault that arrives while a handler is being invoked delivers vector 8 with class abort (exc_class_o = 2) and ret_next_o = 0. A trap in that window is delivered normally.
- R10: Any exception that arrives while the double-fault handler is being invoked delivers nothing. Instead it raises shutdown_req_o for exactly one cycle and sets shutdown_o.
- R11: invoke_done_i returns the level to normal. If a request arrives in the same cycle, the request is judged against the normal level.
- R12: Once set, shutdown_o stays 1 and every request and done strobe is ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cause_i | input | 11 | Exception cause bits (positions per requirements) |
| swint_imm_i | input | VEC_W (8) | Immediate of the software interrupt |
| ovf_i | input | 1 | Overflow flag |
| real_mode_i | input | 1 | Processor runs in real mode |
| invoke_done_i | input | 1 | Handler invocation completed |
| exc_valid_o | output | 1 | One-cycle delivery strobe |
| exc_vector_o | output | VEC_W (8) | Delivered vector |
| exc_class_o | output | 2 | 0 fault, 1 trap, 2 abort |
| ret_next_o | output | 1 | 1: return after the instruction, 0: re-execute it |
| shutdown_o | output | 1 | Shutdown state level |
| shutdown_req_o | output | 1 | One-cycle shutdown broadcast request |

## Verification
The bench first applies every cause on its own, so each vector, class and return point is tied to a single cause bit. It then applies groups of causes at once to show that the lowest vector wins, including a case where an immediate equals a fixed vector. The same causes are repeated with real mode on and off to separate the dropped causes from the stack case. Chains of fault, trap and done strobes drive the escalation through its levels, which tells apart normal delivery, double-fault promotion, serial trap delivery, done-before-request ordering and the sticky shutdown that only reset clears.

// File: rtl/exc_pkg.sv
package exc_pkg;

   typedef enum logic [1:0] {
      CLS_FAULT = 2'd0,
      CLS_TRAP  = 2'd1,
      CLS_ABORT = 2'd2
   } exc_class_e;

   typedef enum logic [1:0] {
      ESC_IDLE   = 2'd0,
      ESC_INVOKE = 2'd1,
      ESC_DOUBLE = 2'd2,
      ESC_DOWN   = 2'd3
   } esc_level_e;

   localparam int NCAUSE  = 11;
   localparam int C_DIVZ  = 0;
   localparam int C_BRKPT = 1;
   localparam int C_OVCHK = 2;
   localparam int C_BOUND = 3;
   localparam int C_INVOP = 4;
   localparam int C_BADTS = 5;
   localparam int C_SEGNP = 6;
   localparam int C_STKNP = 7;
   localparam int C_GPROT = 8;
   localparam int C_PAGEF = 9;
   localparam int C_SWINT = 10;

   localparam int DF_VECTOR = 8;

   function automatic int fixed_vector(input int idx);
      case (idx)
         C_DIVZ:  return 0;
         C_BRKPT: return 3;
         C_OVCHK: return 4;
         C_BOUND: return 5;
         C_INVOP: return 6;
         C_BADTS: return 10;
         C_SEGNP: return 11;
         C_STKNP: return 12;
         C_GPROT: return 13;
         C_PAGEF: return 14;
         default: return 0;
      endcase
   endfunction

   function automatic exc_class_e fixed_class(input int idx);
      if (idx == C_BRKPT || idx == C_OVCHK || idx == C_SWINT) return CLS_TRAP;
      return CLS_FAULT;
   endfunction

   function automatic bit dropped_in_real(input int idx);
      return (idx == C_BADTS) || (idx == C_SEGNP) || (idx == C_PAGEF);
   endfunction

endpackage

// File: rtl/exc_prio.sv
module exc_prio
   import exc_pkg::*;
#(
   parameter int VEC_W = 8
) (
   input  logic [NCAUSE-1:0] cause,
   input  logic [VEC_W-1:0]  imm,
   input  logic              ovf,
   input  logic              real_mode,
   output logic              hit,
   output logic [VEC_W-1:0]  vec,
   output exc_class_e        cls
);

   logic [NCAUSE-1:0]            live;
   logic [NCAUSE-1:0][VEC_W-1:0] cand_vec;
   exc_class_e [NCAUSE-1:0]      cand_cls;

   for (genvar i = 0; i < NCAUSE; i++) begin : g_cause
      if (i == C_SWINT) begin : g_soft
         assign live[i]     = cause[i];
         assign cand_vec[i] = imm;
         assign cand_cls[i] = CLS_TRAP;
      end else if (i == C_OVCHK) begin : g_cond
         assign live[i]     = cause[i] & ovf;
         assign cand_vec[i] = VEC_W'(fixed_vector(i));
         assign cand_cls[i] = fixed_class(i);
      end else if (dropped_in_real(i)) begin : g_prot
         assign live[i]     = cause[i] & ~real_mode;
         assign cand_vec[i] = VEC_W'(fixed_vector(i));
         assign cand_cls[i] = fixed_class(i);
      end else begin : g_plain
         assign live[i]     = cause[i];
         assign cand_vec[i] = VEC_W'(fixed_vector(i));
         assign cand_cls[i] = fixed_class(i);
      end
   end

   // lowest vector wins; the immediate sits at the top index so a tie loses
   always_comb begin
      hit = 1'b0;
      vec = '0;
      cls = CLS_FAULT;
      for (int i = 0; i < NCAUSE; i++) begin
         if (live[i] && (!hit || cand_vec[i] < vec)) begin
            hit = 1'b1;
            vec = cand_vec[i];
            cls = cand_cls[i];
         end
      end
   end

   always_comb begin
      if (real_mode && !cause[C_SWINT] && !cause[C_OVCHK])
         a_r7_real_drop: assert (!(hit && (vec == VEC_W'(10) || vec == VEC_W'(11) || vec == VEC_W'(14))))
            else $error("dropped cause delivered in real mode");
   end

endmodule

// File: rtl/exc_escalate.sv
module exc_escalate
   import exc_pkg::*;
#(
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic [VEC_W-1:0] cand_vec,
   input  exc_class_e       cand_cls,
   input  logic             done,
   output logic             dlv,
   output logic [VEC_W-1:0] dlv_vec,
   output exc_class_e       dlv_cls,
   output logic             go_down,
   output esc_level_e       level
);

   esc_level_e eff, nxt;

   // a done strobe is applied before the request of the same cycle
   always_comb begin
      eff = level;
      if (done && level != ESC_DOWN) eff = ESC_IDLE;
   end

   always_comb begin
      nxt     = eff;
      dlv     = 1'b0;
      dlv_vec = cand_vec;
      dlv_cls = cand_cls;
      go_down = 1'b0;
      if (hit) begin
         case (eff)
            ESC_IDLE: begin
               dlv = 1'b1;
               nxt = ESC_INVOKE;
            end
            ESC_INVOKE: begin
               dlv = 1'b1;
               if (cand_cls == CLS_FAULT) begin
                  dlv_vec = VEC_W'(DF_VECTOR);
                  dlv_cls = CLS_ABORT;
                  nxt     = ESC_DOUBLE;
               end
            end
            ESC_DOUBLE: begin
               go_down = 1'b1;
               nxt     = ESC_DOWN;
            end
            default: nxt = ESC_DOWN;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) level <= ESC_IDLE;
      else        level <= nxt;
   end

   a_r12_down_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      level == ESC_DOWN |=> level == ESC_DOWN)
      else $error("shutdown level left without reset");

   a_r11_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !hit && level != ESC_DOWN) |=> level == ESC_IDLE)
      else $error("done strobe did not return to normal");

endmodule

// File: rtl/exc_escalator.sv
module exc_escalator
   import exc_pkg::*;
#(
   parameter int VEC_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCAUSE-1:0] cause_i,
   input  logic [VEC_W-1:0]  swint_imm_i,
   input  logic              ovf_i,
   input  logic              real_mode_i,
   input  logic              invoke_done_i,
   output logic              exc_valid_o,
   output logic [VEC_W-1:0]  exc_vector_o,
   output logic [1:0]        exc_class_o,
   output logic              ret_next_o,
   output logic              shutdown_o,
   output logic              shutdown_req_o
);

   initial begin
      a_vec_w_ok: assert (VEC_W >= 4) else $error("VEC_W too narrow for fixed vectors");
   end

   logic             p_hit;
   logic [VEC_W-1:0] p_vec;
   exc_class_e       p_cls;
   logic             d_dlv, d_down;
   logic [VEC_W-1:0] d_vec;
   exc_class_e       d_cls;
   esc_level_e       lvl;

   exc_prio #(.VEC_W(VEC_W)) u_prio (
      .cause     (cause_i),
      .imm       (swint_imm_i),
      .ovf       (ovf_i),
      .real_mode (real_mode_i),
      .hit       (p_hit),
      .vec       (p_vec),
      .cls       (p_cls)
   );

   exc_escalate #(.VEC_W(VEC_W)) u_esc (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (p_hit),
      .cand_vec (p_vec),
      .cand_cls (p_cls),
      .done     (invoke_done_i),
      .dlv      (d_dlv),
      .dlv_vec  (d_vec),
      .dlv_cls  (d_cls),
      .go_down  (d_down),
      .level    (lvl)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exc_valid_o    <= 1'b0;
         exc_vector_o   <= '0;
         exc_class_o    <= 2'd0;
         ret_next_o     <= 1'b0;
         shutdown_o     <= 1'b0;
         shutdown_req_o <= 1'b0;
      end else begin
         exc_valid_o    <= d_dlv;
         shutdown_req_o <= d_down;
         if (d_down) shutdown_o <= 1'b1;
         if (d_dlv) begin
            exc_vector_o <= d_vec;
            exc_class_o  <= d_cls;
            ret_next_o   <= (d_cls == CLS_TRAP);
         end
      end
   end

   a_r10_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_req_o |=> !shutdown_req_o)
      else $error("shutdown request longer than one cycle");

   a_r10_quiet_down: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_o |-> !exc_valid_o)
      else $error("delivery while in shutdown");

   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_o |=> shutdown_o)
      else $error("shutdown output dropped");

   a_r9_abort_is_df: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid_o && exc_class_o == 2'd2) |-> exc_vector_o == VEC_W'(DF_VECTOR))
      else $error("abort with wrong vector");

   a_r10_req_with_level: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_req_o |-> shutdown_o && lvl == ESC_DOWN)
      else $error("shutdown request without shutdown state");

endmodule

// File: tb/tb_exc_escalator.sv
module tb_exc_escalator;
   localparam int CLK_PERIOD = 10;
   localparam int VW = 8;

   localparam int B_DIVZ = 0, B_BRK = 1, B_OVC = 2, B_BND = 3, B_INV = 4, B_TSS = 5;
   localparam int B_SNP = 6, B_STK = 7, B_GP = 8, B_PF = 9, B_SW = 10;

   typedef struct {
      bit    v;
      int    vec;
      int    cls;
      bit    sd;
      bit    sq;
      string tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [10:0]   cause = '0;
   logic [VW-1:0] imm = '0;
   logic          ovf = 1'b0, rm = 1'b0, dn = 1'b0;
   logic          ev;
   logic [VW-1:0] evec;
   logic [1:0]    ecls;
   logic          eret, esd, esq;

   exp_t q[$];
   int   n_vec = 0, n_bad = 0;
   bit   finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   exc_escalator #(.VEC_W(VW)) dut (
      .clk(clk), .rst_n(rst_n), .cause_i(cause), .swint_imm_i(imm),
      .ovf_i(ovf), .real_mode_i(rm), .invoke_done_i(dn),
      .exc_valid_o(ev), .exc_vector_o(evec), .exc_class_o(ecls),
      .ret_next_o(eret), .shutdown_o(esd), .shutdown_req_o(esq)
   );

   function automatic bit bitof(input int b);
      return 1'b1;
   endfunction

   task automatic apply(input logic [10:0] c, input int im, input bit o, input bit r,
                        input bit d, input bit xv, input int xvec, input int xcls,
                        input bit xsd, input bit xsq, input string tag);
      exp_t e;
      @(negedge clk);
      cause = c; imm = VW'(im); ovf = o; rm = r; dn = d;
      e.v = xv; e.vec = xvec; e.cls = xcls; e.sd = xsd; e.sq = xsq; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic idle(input bit d, input bit xsd, input string tag);
      apply('0, 0, 0, 0, d, 0, 0, 0, xsd, 0, tag);
   endtask

   function automatic logic [10:0] cb(input int b);
      return 11'(1) << b;
   endfunction

   // monitor: compares one expected item per clock edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            bit   bad;
            e = q.pop_front();
            n_vec++;
            bad = (ev !== e.v) || (esd !== e.sd) || (esq !== e.sq);
            if (e.v && (evec !== VW'(e.vec) || ecls !== 2'(e.cls) || eret !== (e.cls == 1)))
               bad = 1;
            if (bad) begin
               n_bad++;
               $display("FAIL %s: got v=%0b vec=%0d cls=%0d ret=%0b sd=%0b sq=%0b exp v=%0b vec=%0d cls=%0d ret=%0b sd=%0b sq=%0b",
                        e.tag, ev, evec, ecls, eret, esd, esq, e.v, e.vec, e.cls, e.cls == 1, e.sd, e.sq);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: got hang exp completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_vec++;
      if (ev !== 0 || esd !== 0 || esq !== 0) begin
         n_bad++;
         $display("FAIL R1: got v=%0b sd=%0b sq=%0b exp 0 0 0", ev, esd, esq);
      end
      rst_n = 1'b1;
      idle(0, 0, "R1 after reset");
      // single causes
      apply(cb(B_DIVZ), 0, 0, 0, 0, 1, 0, 0, 0, 0, "R5 divz");
      idle(1, 0, "R11 done");
      apply(cb(B_BRK), 0, 0, 0, 0, 1, 3, 1, 0, 0, "R4 brk");
      idle(1, 0, "R11 done");
      apply(cb(B_SW), 8'h21, 0, 0, 0, 1, 33, 1, 0, 0, "R2 swint");
      idle(1, 0, "R11 done");
      apply(cb(B_OVC), 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 ovf clear");
      apply(cb(B_OVC), 0, 1, 0, 0, 1, 4, 1, 0, 0, "R3 ovf set");
      idle(1, 0, "R11 done");
      apply(cb(B_BND), 0, 0, 0, 0, 1, 5, 0, 0, 0, "R5 bound");
      idle(1, 0, "R11 done");
      apply(cb(B_INV), 0, 0, 0, 0, 1, 6, 0, 0, 0, "R5 invop");
      idle(1, 0, "R11 done");
      // priority
      apply(cb(B_BND) | cb(B_INV) | cb(B_BRK), 0, 0, 0, 0, 1, 3, 1, 0, 0, "R8 mix");
      idle(1, 0, "R11 done");
      apply(cb(B_SW) | cb(B_INV), 2, 0, 0, 0, 1, 2, 1, 0, 0, "R8 imm low");
      idle(1, 0, "R11 done");
      apply(cb(B_SW) | cb(B_BND), 5, 0, 0, 0, 1, 5, 0, 0, 0, "R8 tie");
      idle(1, 0, "R11 done");
      // real mode and segment causes
      apply(cb(B_SNP), 0, 0, 1, 0, 0, 0, 0, 0, 0, "R7 segnp real");
      apply(cb(B_PF), 0, 0, 1, 0, 0, 0, 0, 0, 0, "R7 pf real");
      apply(cb(B_TSS), 0, 0, 1, 0, 0, 0, 0, 0, 0, "R7 tss real");
      apply(cb(B_STK), 0, 0, 1, 0, 1, 12, 0, 0, 0, "R6 R7 stack real");
      idle(1, 0, "R11 done");
      apply(cb(B_SNP), 0, 0, 0, 0, 1, 11, 0, 0, 0, "R6 segnp");
      idle(1, 0, "R11 done");
      apply(cb(B_TSS), 0, 0, 0, 0, 1, 10, 0, 0, 0, "R7 tss prot");
      idle(1, 0, "R11 done");
      apply(cb(B_PF) | cb(B_GP), 0, 0, 0, 0, 1, 13, 0, 0, 0, "R5 R8 gp");
      idle(1, 0, "R11 done");
      apply(cb(B_PF), 0, 0, 0, 0, 1, 14, 0, 0, 0, "R7 pf prot");
      idle(1, 0, "R11 done");
      // escalation
      apply(cb(B_DIVZ), 0, 0, 0, 0, 1, 0, 0, 0, 0, "R9 first");
      apply(cb(B_GP), 0, 0, 0, 0, 1, 8, 2, 0, 0, "R9 df");
      idle(1, 0, "R11 done");
      apply(cb(B_BRK), 0, 0, 0, 0, 1, 3, 1, 0, 0, "R9 trap first");
      apply(cb(B_BRK), 0, 0, 0, 0, 1, 3, 1, 0, 0, "R9 trap serial");
      apply(cb(B_DIVZ), 0, 0, 0, 0, 1, 8, 2, 0, 0, "R9 df after trap");
      apply(cb(B_DIVZ), 0, 0, 0, 1, 1, 0, 0, 0, 0, "R11 done with req");
      apply(cb(B_OVC), 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 no level change");
      apply(cb(B_INV), 0, 0, 0, 0, 1, 8, 2, 0, 0, "R3 R9 still invoking");
      apply(cb(B_BRK), 0, 0, 0, 0, 0, 0, 0, 1, 1, "R10 shutdown");
      idle(0, 1, "R10 pulse end");
      apply(cb(B_DIVZ), 0, 0, 0, 0, 0, 0, 0, 1, 0, "R12 ignore req");
      idle(1, 1, "R12 ignore done");
      apply(cb(B_BRK), 0, 0, 0, 0, 0, 0, 0, 1, 0, "R12 ignore after done");
      @(negedge clk);
      rst_n = 1'b0;
      idle(0, 0, "R1 R12 reset clears");
      @(negedge clk);
      rst_n = 1'b1;
      apply(cb(B_BRK), 0, 0, 0, 0, 1, 3, 1, 0, 0, "R12 after reset");
      idle(0, 0, "R1 tail");
      repeat (3) @(posedge clk);
      #3;
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule